// File: doc/BRIEF.md
# Host Memory Access Port with Page Selection

This block is a slave port through which an external host reads and writes the program memory and the data memory inside a processor. The host drives a 16-bit data word together with select, address-latch, read and write strobes, and it watches an acknowledge line. The port holds a 14-bit transfer address that advances by one after every completed access. Each memory type is banked into pages that sit behind that flat address, so the port also holds a page number for each memory type.

A latched word does one of two jobs, and its top bit chooses which. With the top bit clear, the word loads a new start address and selects the target memory. With the top bit set, the word loads both page fields and leaves the address as it is. The host can therefore set up a banked transfer with two latch cycles, given in either order. The memories sit outside the block behind a simple synchronous request interface. A mode input decides whether the acknowledge pin drives both levels or only pulls low.

Top module: `host_dma_port`

## Requirements
- R1: After reset the port is ready (acknowledge high), issues no memory request, and holds transfer address 0, target program memory and both pages 0.
- R2: A latch (hostSel and hostLatch) with bit 15 = 0 sets the transfer address to bits 13:0 and the target to bit 14 (0 = program memory, 1 = data memory). Both pages stay unchanged.
- R3: A latch with bit 15 = 1 sets the data-memory page to bits 3:0 and the program-memory page to bits 7:4. It leaves the address and the target unchanged, and bits 14:8 have no effect.
- R4: During a request, memSel shows the target (0 program, 1 data) and memPage shows that target's page as held when the access was accepted.
- R5: When the port is ready, a read or write strobe is accepted. Acknowledge is then low for exactly two clock cycles and returns high on the third.
- R6: An accepted access raises memReq for exactly the one cycle after acceptance. memAddr is the transfer address, memWe is 1 for a write, and memWdata is the data word captured at acceptance.
- R7: For a read, hostDataOut holds the word the memory returned once acknowledge is high again. hostDataOe equals hostSel and hostRd.
- R8: Each completed access increments the transfer address by one, and 0x3FFF wraps to 0x0000.
- R9: Read or write strobes that arrive while acknowledge is low are ignored and start no further access.
- R10: An address latch in the completion cycle replaces the increment. A page latch in the completion cycle takes effect together with the increment.
- R11: With odMode = 1, ackOut is 0 and ackOe is high only while acknowledge is low. With odMode = 0, ackOe is 1 and ackOut carries the acknowledge level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| odMode | input | 1 | 1: acknowledge pulls low only; 0: acknowledge drives both levels |
| hostSel | input | 1 | Port select |
| hostLatch | input | 1 | Latch strobe for an address or page word |
| hostRd | input | 1 | Read strobe |
| hostWr | input | 1 | Write strobe |
| hostDataIn | input | 16 | Host data/control word |
| hostDataOut | output | 16 | Read data to host |
| hostDataOe | output | 1 | Drive enable for hostDataOut |
| ackOut | output | 1 | Acknowledge pin value |
| ackOe | output | 1 | Acknowledge pin drive enable |
| memReq | output | 1 | Memory request, one cycle |
| memWe | output | 1 | Memory write enable |
| memSel | output | 1 | 0 program memory, 1 data memory |
| memPage | output | 4 | Page of the selected memory |
| memAddr | output | 14 | Word address within the page window |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid one cycle after memReq |

## Verification
The address increment at the end of an access and a host latch can land on the same clock edge. The bench forces this by raising the latch strobe in the second low-acknowledge cycle, with either an address word or a page word. The next access is then judged by its memAddr, memSel and memPage. An address word must win outright over the increment, while a page word must leave the incremented address in place and take effect as well. A second case holds the read or write strobe through the whole busy window; there, exactly one request must appear and the address must advance by only one.

// File: rtl/hdp_pkg.sv
package hdp_pkg;
  // strobes the control path hands to the datapath each cycle
  typedef struct packed {
    logic loadAddr;  // latch word carries a start address
    logic loadPage;  // latch word carries page numbers
    logic issue;     // access accepted this cycle
    logic complete;  // access finishes this cycle
  } hdpStrobes_t;
endpackage

// File: rtl/hdp_ctrl.sv
module hdp_ctrl
  import hdp_pkg::*;
#(
  parameter int ACK_LOW = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostSel,
  input  logic        hostLatch,
  input  logic        hostRd,
  input  logic        hostWr,
  input  logic        selBit,
  output logic        ready,
  output hdpStrobes_t strb
);
  localparam int CNT_W = (ACK_LOW > 1) ? $clog2(ACK_LOW) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_LOW - 1);

  typedef enum logic {ST_IDLE, ST_BUSY} state_t;
  state_t state;
  logic [CNT_W-1:0] lowCnt;
  logic accept;

  assign accept = (state == ST_IDLE) && hostSel && (hostRd || hostWr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      lowCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_BUSY;
          lowCnt <= '0;
        end
        ST_BUSY: if (lowCnt == LAST) state <= ST_IDLE;
                 else lowCnt <= lowCnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.issue    = accept;
    strb.complete = (state == ST_BUSY) && (lowCnt == LAST);
    strb.loadAddr = hostSel && hostLatch && !selBit;
    strb.loadPage = hostSel && hostLatch && selBit;
  end

  assign ready = (state == ST_IDLE);

  // acknowledge drops right after an accepted strobe
  p_ack_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |=> !ready);

  // a strobe seen while busy never starts an access
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && hostSel && (hostRd || hostWr)) |-> !strb.issue);

  generate
    if (ACK_LOW == 2) begin : g_twoLow
      p_ack_back_r5: assert property (@(posedge clk) disable iff (!rstN)
        (!ready && $past(!ready)) |=> ready);
    end
  endgenerate
endmodule

// File: rtl/hdp_datapath.sv
module hdp_datapath
  import hdp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  hdpStrobes_t       strb,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              memReq,
  output logic              memWe,
  output logic              memSel,
  output logic [PAGE_W-1:0] memPage,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);
  localparam int TYPE_BIT = DATA_W - 2;

  logic [ADDR_W-1:0] addrReg;
  logic              typeReg;
  logic [PAGE_W-1:0] pmPage, dmPage;
  logic              opWrite;

  // transfer address and target; an address latch beats the increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      typeReg <= 1'b0;
    end else if (strb.loadAddr) begin
      addrReg <= hostDataIn[ADDR_W-1:0];
      typeReg <= hostDataIn[TYPE_BIT];
    end else if (strb.complete) begin
      addrReg <= addrReg + 1'b1;
    end
  end

  // page register, reserved bits of the word are dropped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pmPage <= '0;
      dmPage <= '0;
    end else if (strb.loadPage) begin
      dmPage <= hostDataIn[PAGE_W-1:0];
      pmPage <= hostDataIn[2*PAGE_W-1:PAGE_W];
    end
  end

  // per-access snapshot driving the memory request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memReq   <= 1'b0;
      memWe    <= 1'b0;
      memSel   <= 1'b0;
      memPage  <= '0;
      memAddr  <= '0;
      memWdata <= '0;
      opWrite  <= 1'b0;
    end else begin
      memReq <= strb.issue;
      if (strb.issue) begin
        memWe    <= hostWr;
        opWrite  <= hostWr;
        memSel   <= typeReg;
        memPage  <= typeReg ? dmPage : pmPage;
        memAddr  <= addrReg;
        memWdata <= hostDataIn;
      end else begin
        memWe <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostDataOut <= '0;
    else if (strb.complete && !opWrite) hostDataOut <= memRdata;
  end

  p_page_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadAddr && !strb.loadPage) |=> ($stable(pmPage) && $stable(dmPage)));

  p_addr_incr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.complete && !strb.loadAddr) |=> (addrReg == ADDR_W'($past(addrReg) + 1'b1)));

  p_addr_latch_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadAddr |=> (addrReg == $past(hostDataIn[ADDR_W-1:0])));

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
endmodule

// File: rtl/host_dma_port.sv
module host_dma_port
  import hdp_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 14,
  parameter int PAGE_W  = 4,
  parameter int ACK_LOW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              odMode,
  input  logic              hostSel,
  input  logic              hostLatch,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic              ackOut,
  output logic              ackOe,
  output logic              memReq,
  output logic              memWe,
  output logic              memSel,
  output logic [PAGE_W-1:0] memPage,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);
  hdpStrobes_t strb;
  logic ready;

  hdp_ctrl #(.ACK_LOW(ACK_LOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostLatch(hostLatch),
    .hostRd(hostRd), .hostWr(hostWr), .selBit(hostDataIn[DATA_W-1]),
    .ready(ready), .strb(strb)
  );

  hdp_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWr(hostWr),
    .hostDataIn(hostDataIn), .hostDataOut(hostDataOut),
    .memReq(memReq), .memWe(memWe), .memSel(memSel), .memPage(memPage),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  assign hostDataOe = hostSel && hostRd;
  assign ackOut     = odMode ? 1'b0 : ready;
  assign ackOe      = odMode ? !ready : 1'b1;

  p_od_drive_r11: assert property (@(posedge clk) disable iff (!rstN)
    odMode |-> (!ackOut && (ackOe != ready)));

  p_pp_drive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !odMode |-> (ackOe && (ackOut == ready)));
endmodule

// File: tb/tb_host_dma_port.sv
module tb_host_dma_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic odMode = 1'b0;
  logic hostSel = 1'b0, hostLatch = 1'b0, hostRd = 1'b0, hostWr = 1'b0;
  logic [15:0] hostDataIn = '0;
  logic [15:0] hostDataOut, memWdata;
  logic [15:0] memRdata = '0;
  logic hostDataOe, ackOut, ackOe, memReq, memWe, memSel;
  logic [3:0]  memPage;
  logic [13:0] memAddr;

  int nChecks = 0, nFails = 0;
  logic [13:0] eAddr = '0;
  logic eType = 1'b0;
  logic [3:0] ePm = '0, eDm = '0;
  logic [15:0] ram [int];

  always #10 clk = ~clk;

  host_dma_port dut (
    .clk(clk), .rstN(rstN), .odMode(odMode), .hostSel(hostSel),
    .hostLatch(hostLatch), .hostRd(hostRd), .hostWr(hostWr),
    .hostDataIn(hostDataIn), .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
    .ackOut(ackOut), .ackOe(ackOe), .memReq(memReq), .memWe(memWe),
    .memSel(memSel), .memPage(memPage), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  function automatic int keyOf(logic t, logic [3:0] p, logic [13:0] a);
    return int'({t, p, a});
  endfunction

  function automatic logic [15:0] peek(int k);
    if (ram.exists(k)) return ram[k];
    return 16'(k) ^ 16'hA5C3;
  endfunction

  // synchronous memory model
  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) ram[keyOf(memSel, memPage, memAddr)] = memWdata;
      else memRdata <= peek(keyOf(memSel, memPage, memAddr));
    end
  end

  function automatic logic ackLvl();
    return ackOe ? ackOut : 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic applyLatch(input logic [15:0] w);
    if (w[15]) begin
      eDm = w[3:0];
      ePm = w[7:4];
    end else begin
      eAddr = w[13:0];
      eType = w[14];
    end
  endtask

  task automatic doLatch(input logic [15:0] w);
    @(negedge clk);
    hostSel = 1; hostLatch = 1; hostDataIn = w;
    @(negedge clk);
    hostSel = 0; hostLatch = 0;
    applyLatch(w);
  endtask

  // one access; hold keeps the strobe through the busy window,
  // col puts a latch word on the completion edge
  task automatic doAccess(input bit wr, input logic [15:0] d, input bit hold,
                          input bit col, input logic [15:0] colWord);
    logic [15:0] expRd;
    @(negedge clk);
    hostSel = 1; hostWr = wr; hostRd = !wr; hostDataIn = d;
    @(negedge clk);
    if (!hold) begin hostSel = 0; hostWr = 0; hostRd = 0; end
    chk(ackLvl() == 1'b0, "R5 ack low 1", 32'(ackLvl()), 0);
    chk(odMode ? (!ackOut && ackOe) : (ackOe && !ackOut), "R11 busy pin", {ackOe, ackOut}, odMode ? 2 : 2);
    chk(memReq == 1'b1, "R6 req", 32'(memReq), 1);
    chk(memAddr == eAddr, "R6 addr", 32'(memAddr), 32'(eAddr));
    chk(memWe == wr, "R6 we", 32'(memWe), 32'(wr));
    chk(memSel == eType, "R4 sel", 32'(memSel), 32'(eType));
    chk(memPage == (eType ? eDm : ePm), "R4 page", 32'(memPage), 32'(eType ? eDm : ePm));
    if (wr) chk(memWdata == d, "R6 wdata", 32'(memWdata), 32'(d));
    expRd = peek(keyOf(eType, eType ? eDm : ePm, eAddr));
    @(negedge clk);
    chk(ackLvl() == 1'b0, "R5 ack low 2", 32'(ackLvl()), 0);
    chk(memReq == 1'b0, "R6 single req", 32'(memReq), 0);
    if (col) begin
      hostSel = 1; hostLatch = 1; hostDataIn = colWord;
    end
    @(negedge clk);
    hostLatch = 0;
    chk(ackLvl() == 1'b1, "R5 ack back", 32'(ackLvl()), 1);
    chk(odMode ? !ackOe : (ackOe && ackOut), "R11 idle pin", {ackOe, ackOut}, odMode ? 0 : 3);
    if (!wr) begin
      hostSel = 1; hostRd = 1;
      #1;
      chk(hostDataOut == expRd, "R7 rdata", 32'(hostDataOut), 32'(expRd));
      chk(hostDataOe == 1'b1, "R7 oe", 32'(hostDataOe), 1);
    end
    hostSel = 0; hostRd = 0; hostWr = 0;
    #1;
    chk(hostDataOe == 1'b0, "R7 oe off", 32'(hostDataOe), 0);
    eAddr = eAddr + 14'd1;
    if (col) applyLatch(colWord);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1187));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(ackLvl() == 1'b1, "R1 ack", 32'(ackLvl()), 1);
    chk(memReq == 1'b0, "R1 req", 32'(memReq), 0);
    doAccess(0, 16'h0, 0, 0, 16'h0);            // R1: addr 0, PM, page 0
    // R3 page word with junk in the reserved bits
    doLatch(16'hFF35);
    doAccess(1, 16'h1234, 0, 0, 16'h0);
    // R2 address word targeting data memory, pages kept
    doLatch(16'h6000);
    doAccess(1, 16'hBEEF, 0, 0, 16'h0);
    doLatch(16'h6000);
    doAccess(0, 16'h0, 0, 0, 16'h0);            // reads back BEEF
    // R8 wrap at the top of the window
    doLatch(16'h3FFF);
    doAccess(1, 16'h0F0F, 0, 0, 16'h0);
    doAccess(0, 16'h0, 0, 0, 16'h0);            // expects address 0
    // R9 strobe held through busy
    doAccess(0, 16'h0, 1, 0, 16'h0);
    doAccess(1, 16'h5555, 1, 0, 16'h0);
    doAccess(0, 16'h0, 0, 0, 16'h0);
    // R10 address latch on the completion edge wins
    doAccess(1, 16'h7777, 0, 1, 16'h4123);
    doAccess(0, 16'h0, 0, 0, 16'h0);
    // R10 page latch on the completion edge plus increment
    doAccess(1, 16'h8888, 0, 1, 16'h8092);
    doAccess(0, 16'h0, 0, 0, 16'h0);
    // R11 pull-low-only acknowledge
    odMode = 1;
    @(negedge clk);
    chk(!ackOe && !ackOut, "R11 od idle", {ackOe, ackOut}, 0);
    doAccess(0, 16'h0, 0, 0, 16'h0);
    doAccess(1, 16'h2468, 0, 0, 16'h0);
    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [15:0] w;
      sel = int'($urandom_range(0, 9));
      w = 16'($urandom);
      if (($urandom_range(0, 19)) == 0) odMode = !odMode;
      if (sel == 0) doLatch({1'b1, w[14:0]});
      else if (sel == 1) doLatch({1'b0, w[14:0]});
      else if (sel == 2) doAccess(w[0], w, 0, 1, {w[1], 15'($urandom)});
      else if (sel == 3) doAccess(w[0], w, 1, 0, 16'h0);
      else doAccess(w[0], w, 0, 0, 16'h0);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule